// File: doc/BRIEF.md
# Per-CPU Interrupt Acknowledge and End-of-Interrupt Unit

This unit sits between the shared interrupt-source logic of an interrupt controller and one processor. The source logic forwards a source index whenever that source should be offered to this processor. The unit keeps two bit sets over all source indices. One holds the sources raised to this processor. The other holds the sources the processor is servicing. It picks the highest-priority raised source and drives a level interrupt request to the processor.

The processor talks to the unit through a small register port. It can set its task priority threshold. It reads an acknowledge register that returns the vector of the winning source, or a spurious vector when no valid source is left. It writes an end-of-interrupt register to retire the top in-service source. Per-source priority, vector, activity and sense values come in as flat buses. The unit reports changes of activity and pending state back to the source logic as single-cycle strobes. Source configuration itself lives elsewhere.

Top module: `cpu_intr_gate`

## Requirements
- R1: The task priority register (address 0) is 4 bits wide and resets to 0xF. A write keeps only write-data bits 3:0. A read returns it zero-extended.
- R2: A forwarded source is dropped, with no activity-set strobe and no change of state, when its 5-bit priority is less than or equal to the task priority or when it is already in the raised set.
- R3: An accepted forward pulses the activity-set strobe with that index in the same cycle and sets the raised bit. If the source's priority exceeds the highest raised priority (an empty set counting as -1), the request output is high from the next cycle.
- R4: The winner of the raised or in-service set is the source with the highest priority. Among equal priorities the lowest index wins.
- R5: The spurious vector register (address 4) is 8 bits wide, resets to 0xFF and keeps write-data bits 7:0. An acknowledge read (address 2) with an empty raised set returns it.
- R6: An acknowledge read whose winner has its activity input low, or whose priority no longer exceeds the task priority, pulses the activity-clear strobe for that winner. It returns the spurious vector and leaves the in-service set unchanged.
- R7: A valid acknowledge read places the winner in the in-service set, returns its 8-bit vector and drives the request output low.
- R8: Every acknowledge read that finds a winner clears that winner's raised bit. When the winner is edge-sensitive (sense input 0; 1 means level), the read also pulses both the activity-clear and the pending-clear strobes.
- R9: An end-of-interrupt write (address 3) clears the top in-service source. The request goes high if the top raised priority exceeds the new top in-service priority, or if raised sources remain and the in-service set is now empty.
- R10: Read data appears on the read-data output in the cycle after the read strobe. Reading address 3 returns 0, address 1 returns the CPU index parameter, and addresses 5 to 7 return all ones.
- R11: The request output is a level. It falls only after a valid acknowledge read and otherwise holds until an assert condition from R3 or R9 occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fwd_valid_i | input | 1 | Forward strobe from the source logic |
| fwd_idx_i | input | IW | Index of the forwarded source |
| src_prio_i | input | N*5 | Per-source priority, source i at bits 5i+4:5i |
| src_vec_i | input | N*8 | Per-source vector, source i at bits 8i+7:8i |
| src_active_i | input | N | Per-source activity bit |
| src_level_i | input | N | Per-source sense, 1 level, 0 edge |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt request to the processor |
| act_set_o | output | 1 | Strobe: set activity of act_set_idx_o |
| act_set_idx_o | output | IW | Source whose activity is set |
| act_clr_o | output | 1 | Strobe: clear activity of act_clr_idx_o |
| act_clr_idx_o | output | IW | Source whose activity or pending flag is cleared |
| pend_clr_o | output | 1 | Strobe: clear pending flag of act_clr_idx_o |

## Verification
The assertions check the local rules on every cycle. These are the task priority write, the suppression of forwards at or below the threshold or already raised, the raised bit after an accepted forward, the shrinking of the raised set on each acknowledge and of the in-service set on each end-of-interrupt, the pairing of pending-clear with activity-clear, the zero read of the end-of-interrupt register, and the rule that the request only falls after an acknowledge. Whether the chosen winner is really the highest priority with lowest-index tie-break, which vector comes back, and when the request is raised again after an end-of-interrupt all depend on the whole history of both sets. Only the bench's scenarios show these, comparing against its own model of the two sets.

// File: rtl/cig_pkg.sv
`timescale 1ns/1ps
package cig_pkg;
  localparam int PRIO_W = 5;
  localparam int VEC_W  = 8;
  localparam int TPR_W  = 4;
  localparam int DATA_W = 32;
  localparam int WD_W   = 8;

  typedef enum logic [2:0] {
    RA_TPR  = 3'd0,
    RA_WHO  = 3'd1,
    RA_ACK  = 3'd2,
    RA_EOI  = 3'd3,
    RA_SPUR = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/cig_prio_pick.sv
`timescale 1ns/1ps
module cig_prio_pick #(
  parameter int N  = 64,
  parameter int PW = 5,
  parameter int IW = 6
) (
  input  logic [N-1:0]    req_i,
  input  logic [N*PW-1:0] prio_i,
  output logic            found_o,
  output logic [IW-1:0]   idx_o
);
  logic [PW-1:0] best;

  // ascending scan; strictly greater replaces, so lowest index keeps ties
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    best    = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && (!found_o || (prio_i[i*PW +: PW] > best))) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
        best    = prio_i[i*PW +: PW];
      end
    end
  end
endmodule

// File: rtl/cig_regfile.sv
`timescale 1ns/1ps
module cig_regfile
  import cig_pkg::*;
#(
  parameter int CPU_ID = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [2:0]        addr_i,
  input  logic [WD_W-1:0]   wdata_i,
  input  logic [VEC_W-1:0]  ack_data_i,
  output logic [TPR_W-1:0]  tpr_o,
  output logic [VEC_W-1:0]  spur_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [TPR_W-1:0]  tpr_q,   tpr_d;
  logic [VEC_W-1:0]  spur_q,  spur_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              tpr_en, spur_en;

  assign tpr_en  = wr_i && (addr_i == RA_TPR);
  assign spur_en = wr_i && (addr_i == RA_SPUR);
  assign tpr_d   = wdata_i[TPR_W-1:0];
  assign spur_d  = wdata_i[VEC_W-1:0];

  always_comb begin
    case (addr_i)
      RA_TPR:  rdata_d = DATA_W'(tpr_q);
      RA_WHO:  rdata_d = DATA_W'(CPU_ID);
      RA_ACK:  rdata_d = DATA_W'(ack_data_i);
      RA_EOI:  rdata_d = '0;
      RA_SPUR: rdata_d = DATA_W'(spur_q);
      default: rdata_d = '1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tpr_q   <= '1;
      spur_q  <= '1;
      rdata_q <= '0;
    end else begin
      if (tpr_en)  tpr_q   <= tpr_d;
      if (spur_en) spur_q  <= spur_d;
      if (rd_i)    rdata_q <= rdata_d;
    end
  end

  assign tpr_o   = tpr_q;
  assign spur_o  = spur_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/cpu_intr_gate.sv
`timescale 1ns/1ps
module cpu_intr_gate
  import cig_pkg::*;
#(
  parameter int N      = 64,
  parameter int CPU_ID = 0,
  localparam int IW    = (N > 1) ? $clog2(N) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fwd_valid_i,
  input  logic [IW-1:0]       fwd_idx_i,
  input  logic [N*PRIO_W-1:0] src_prio_i,
  input  logic [N*VEC_W-1:0]  src_vec_i,
  input  logic [N-1:0]        src_active_i,
  input  logic [N-1:0]        src_level_i,
  input  logic                reg_rd_i,
  input  logic                reg_wr_i,
  input  logic [2:0]          reg_addr_i,
  input  logic [WD_W-1:0]     reg_wdata_i,
  output logic [DATA_W-1:0]   reg_rdata_o,
  output logic                irq_o,
  output logic                act_set_o,
  output logic [IW-1:0]       act_set_idx_o,
  output logic                act_clr_o,
  output logic [IW-1:0]       act_clr_idx_o,
  output logic                pend_clr_o
);
  logic [N-1:0]       raised_q, raised_d, serv_q, serv_d, serv_left;
  logic               raised_en, serv_en;
  logic               irq_q, irq_d, irq_en;
  logic [TPR_W-1:0]   tpr;
  logic [VEC_W-1:0]   spur;
  logic [VEC_W-1:0]   ack_data;

  logic               r_found, s_found, a_found;
  logic [IW-1:0]      r_idx, s_idx, a_idx;
  logic [PRIO_W-1:0]  r_prio, a_prio, fwd_prio;
  logic [N-1:0]       s_onehot;

  logic fwd_ok, fwd_accept, fwd_above;
  logic ack_req, ack_hit, ack_stale, ack_ok, w_level;
  logic eoi_req, eoi_raise;

  // winner searches over raised, in-service and in-service-after-retire
  cig_prio_pick #(.N(N), .PW(PRIO_W), .IW(IW)) u_pick_raised (
    .req_i(raised_q), .prio_i(src_prio_i), .found_o(r_found), .idx_o(r_idx));

  cig_prio_pick #(.N(N), .PW(PRIO_W), .IW(IW)) u_pick_serv (
    .req_i(serv_q), .prio_i(src_prio_i), .found_o(s_found), .idx_o(s_idx));

  assign s_onehot  = s_found ? ({{(N-1){1'b0}}, 1'b1} << s_idx) : '0;
  assign serv_left = serv_q & ~s_onehot;

  cig_prio_pick #(.N(N), .PW(PRIO_W), .IW(IW)) u_pick_left (
    .req_i(serv_left), .prio_i(src_prio_i), .found_o(a_found), .idx_o(a_idx));

  cig_regfile #(.CPU_ID(CPU_ID)) u_regs (
    .clk(clk), .rst_n(rst_n), .rd_i(reg_rd_i), .wr_i(reg_wr_i),
    .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .ack_data_i(ack_data),
    .tpr_o(tpr), .spur_o(spur), .rdata_o(reg_rdata_o));

  assign r_prio   = src_prio_i[r_idx * PRIO_W +: PRIO_W];
  assign a_prio   = src_prio_i[a_idx * PRIO_W +: PRIO_W];
  assign fwd_prio = src_prio_i[fwd_idx_i * PRIO_W +: PRIO_W];

  // forward path
  assign fwd_ok     = fwd_valid_i && (int'(fwd_idx_i) < N);
  assign fwd_accept = fwd_ok && (fwd_prio > {1'b0, tpr}) && !raised_q[fwd_idx_i];
  assign fwd_above  = !r_found || (fwd_prio > r_prio);

  // acknowledge path
  assign ack_req   = reg_rd_i && (reg_addr_i == RA_ACK);
  assign ack_hit   = ack_req && r_found;
  assign w_level   = src_level_i[r_idx];
  assign ack_stale = !src_active_i[r_idx] || !(r_prio > {1'b0, tpr});
  assign ack_ok    = ack_hit && !ack_stale;
  assign ack_data  = (r_found && !ack_stale) ? src_vec_i[r_idx * VEC_W +: VEC_W] : spur;

  // end-of-interrupt path
  assign eoi_req   = reg_wr_i && (reg_addr_i == RA_EOI);
  assign eoi_raise = eoi_req && r_found && (!a_found || (r_prio > a_prio));

  // raised set
  assign raised_en = fwd_accept || ack_hit;
  always_comb begin
    raised_d = raised_q;
    if (fwd_accept) raised_d[fwd_idx_i] = 1'b1;
    if (ack_hit)    raised_d[r_idx]     = 1'b0;
  end

  // in-service set
  assign serv_en = ack_ok || (eoi_req && s_found);
  always_comb begin
    serv_d = serv_q;
    if (eoi_req && s_found) serv_d[s_idx] = 1'b0;
    if (ack_ok)             serv_d[r_idx] = 1'b1;
  end

  // request level
  assign irq_en = (fwd_accept && fwd_above) || eoi_raise || ack_ok;
  always_comb begin
    if ((fwd_accept && fwd_above) || eoi_raise) irq_d = 1'b1;
    else                                         irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raised_q <= '0;
      serv_q   <= '0;
      irq_q    <= 1'b0;
    end else begin
      if (raised_en) raised_q <= raised_d;
      if (serv_en)   serv_q   <= serv_d;
      if (irq_en)    irq_q    <= irq_d;
    end
  end

  assign irq_o         = irq_q;
  assign act_set_o     = fwd_accept;
  assign act_set_idx_o = fwd_idx_i;
  assign act_clr_o     = ack_hit && (ack_stale || !w_level);
  assign act_clr_idx_o = r_idx;
  assign pend_clr_o    = ack_hit && !w_level;
endmodule

// File: rtl/cig_checker.sv
`timescale 1ns/1ps
module cig_checker #(
  parameter int N  = 64,
  parameter int PW = 5,
  parameter int IW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fwd_valid,
  input logic [IW-1:0] fwd_idx,
  input logic [N*PW-1:0] src_prio,
  input logic          reg_rd,
  input logic          reg_wr,
  input logic [2:0]    reg_addr,
  input logic [7:0]    reg_wdata,
  input logic [31:0]   reg_rdata,
  input logic          irq,
  input logic          act_set,
  input logic [IW-1:0] act_set_idx,
  input logic          act_clr,
  input logic          pend_clr,
  input logic [N-1:0]  raised,
  input logic [N-1:0]  serv,
  input logic [3:0]    tpr
);
  logic [PW-1:0] fwd_prio;
  assign fwd_prio = src_prio[fwd_idx * PW +: PW];

  assert_tpr_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd0) |=> (tpr == $past(reg_wdata[3:0])));

  assert_drop_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid && (fwd_prio <= {1'b0, tpr})) |-> !act_set);

  assert_drop_dup_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid && raised[fwd_idx]) |-> !act_set);

  assert_accept_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    act_set |=> raised[$past(act_set_idx)]);

  assert_ack_shrinks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 3'd2 && (|raised) && !fwd_valid)
      |=> ($countones(raised) == $past($countones(raised)) - 1));

  assert_pend_with_act_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pend_clr |-> act_clr);

  assert_eoi_retires_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd3 && !reg_rd && (|serv))
      |=> ($countones(serv) == $past($countones(serv)) - 1));

  assert_eoi_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 3'd3) |=> (reg_rdata == 32'd0));

  assert_irq_falls_on_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(reg_rd && reg_addr == 3'd2));
endmodule

bind cpu_intr_gate cig_checker #(.N(N), .PW(cig_pkg::PRIO_W), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fwd_valid(fwd_valid_i), .fwd_idx(fwd_idx_i),
  .src_prio(src_prio_i), .reg_rd(reg_rd_i), .reg_wr(reg_wr_i),
  .reg_addr(reg_addr_i), .reg_wdata(reg_wdata_i), .reg_rdata(reg_rdata_o),
  .irq(irq_o), .act_set(act_set_o), .act_set_idx(act_set_idx_o),
  .act_clr(act_clr_o), .pend_clr(pend_clr_o), .raised(raised_q),
  .serv(serv_q), .tpr(tpr));

// File: tb/cpu_intr_gate_bench.sv
`timescale 1ns/1ps
module cpu_intr_gate_bench;
  localparam int N  = 64;
  localparam int IW = 6;
  localparam int ID = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic fwd_valid;
  logic [IW-1:0] fwd_idx;
  logic [N*5-1:0] src_prio;
  logic [N*8-1:0] src_vec;
  logic [N-1:0] src_active, src_level;
  logic reg_rd, reg_wr;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic irq, act_set, act_clr, pend_clr;
  logic [IW-1:0] act_set_idx, act_clr_idx;

  int  m_prio [N];
  int  m_vec  [N];
  bit  m_level[N];
  bit  m_active[N];
  bit  m_raised[N];
  bit  m_serv [N];
  int  m_tpr, m_spur;
  bit  m_irq;
  int  total = 0;
  int  bad = 0;

  always #2.5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      src_prio[i*5 +: 5]  = 5'(m_prio[i]);
      src_vec[i*8 +: 8]   = 8'(m_vec[i]);
      src_active[i]       = m_active[i];
      src_level[i]        = m_level[i];
    end
  end

  cpu_intr_gate #(.N(N), .CPU_ID(ID)) u_cpu_intr_gate (
    .clk(clk), .rst_n(rst_n), .fwd_valid_i(fwd_valid), .fwd_idx_i(fwd_idx),
    .src_prio_i(src_prio), .src_vec_i(src_vec), .src_active_i(src_active),
    .src_level_i(src_level), .reg_rd_i(reg_rd), .reg_wr_i(reg_wr),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .irq_o(irq), .act_set_o(act_set), .act_set_idx_o(act_set_idx),
    .act_clr_o(act_clr), .act_clr_idx_o(act_clr_idx), .pend_clr_o(pend_clr));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int pick_raised();
    int w = -1;
    for (int i = 0; i < N; i++)
      if (m_raised[i] && (w < 0 || m_prio[i] > m_prio[w])) w = i;
    return w;
  endfunction

  function automatic int pick_serv();
    int w = -1;
    for (int i = 0; i < N; i++)
      if (m_serv[i] && (w < 0 || m_prio[i] > m_prio[w])) w = i;
    return w;
  endfunction

  task automatic fwd(input int i);
    bit acc;
    int t;
    fwd_valid = 1'b1;
    fwd_idx   = IW'(i);
    #1;
    acc = (m_prio[i] > m_tpr) && !m_raised[i];
    t   = pick_raised();
    if (acc) begin
      chk("R3 act_set", {31'd0, act_set}, 32'd1);
      chk("R3 act_set_idx", 32'(act_set_idx), 32'(i));
    end else begin
      chk("R2 act_set dropped", {31'd0, act_set}, 32'd0);
    end
    @(negedge clk);
    fwd_valid = 1'b0;
    if (acc) begin
      if (t < 0 || m_prio[i] > m_prio[t]) m_irq = 1'b1;
      m_raised[i] = 1'b1;
      m_active[i] = 1'b1;
    end
    chk("R3/R11 irq after forward", {31'd0, irq}, {31'd0, m_irq});
  endtask

  task automatic ack(input string req);
    int  t;
    bit  stale;
    logic [31:0] exp;
    reg_rd   = 1'b1;
    reg_addr = 3'd2;
    #1;
    t = pick_raised();
    stale = (t >= 0) && (!m_active[t] || !(m_prio[t] > m_tpr));
    if (t >= 0) begin
      chk("R6/R8 act_clr", {31'd0, act_clr}, {31'd0, (stale || !m_level[t])});
      chk("R8 pend_clr", {31'd0, pend_clr}, {31'd0, !m_level[t]});
      if (stale || !m_level[t]) chk("R8 act_clr_idx", 32'(act_clr_idx), 32'(t));
    end else begin
      chk("R5 no clear on empty", {30'd0, act_clr, pend_clr}, 32'd0);
    end
    @(negedge clk);
    reg_rd = 1'b0;
    if (t < 0) begin
      exp = 32'(m_spur);
    end else begin
      if (stale) begin
        exp = 32'(m_spur);
        m_active[t] = 1'b0;
      end else begin
        exp = 32'(m_vec[t]);
        m_serv[t] = 1'b1;
        m_irq = 1'b0;
      end
      m_raised[t] = 1'b0;
      if (!m_level[t]) m_active[t] = 1'b0;
    end
    chk(req, reg_rdata, exp);
    chk("R7/R11 irq after ack", {31'd0, irq}, {31'd0, m_irq});
  endtask

  task automatic eoi();
    int s, t;
    reg_wr   = 1'b1;
    reg_addr = 3'd3;
    reg_wdata = 8'h00;
    @(negedge clk);
    reg_wr = 1'b0;
    s = pick_serv();
    if (s >= 0) m_serv[s] = 1'b0;
    s = pick_serv();
    t = pick_raised();
    if (t >= 0 && (s < 0 || m_prio[t] > m_prio[s])) m_irq = 1'b1;
    chk("R9 irq after end-of-interrupt", {31'd0, irq}, {31'd0, m_irq});
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_wr = 1'b1;
    reg_addr = a;
    reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    if (a == 3'd0) m_tpr  = int'(d[3:0]);
    if (a == 3'd4) m_spur = int'(d);
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string req);
    reg_rd = 1'b1;
    reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    chk(req, reg_rdata, exp);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd7321));
    rst_n = 1'b0;
    fwd_valid = 1'b0; fwd_idx = '0;
    reg_rd = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    m_tpr = 15; m_spur = 255; m_irq = 1'b0;
    for (int i = 0; i < N; i++) begin
      m_prio[i]  = int'($urandom % 31) + 1;
      m_vec[i]   = (i * 3 + 7) % 256;
      m_level[i] = 1'($urandom % 2);
      m_active[i] = 1'b0;
      m_raised[i] = 1'b0;
      m_serv[i]   = 1'b0;
    end
    m_prio[5] = 2;  m_prio[9] = 10; m_prio[12] = 10; m_prio[20] = 20; m_prio[30] = 8;
    m_level[9] = 1'b0; m_level[12] = 1'b1; m_level[20] = 1'b1; m_level[30] = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    chk("R11 irq low after reset", {31'd0, irq}, 32'd0);
    rd(3'd0, 32'h0000000F, "R1 task priority reset");
    rd(3'd4, 32'h000000FF, "R5 spurious reset");
    rd(3'd1, 32'(ID), "R10 cpu index");
    rd(3'd3, 32'd0, "R10 end-of-interrupt read");
    rd(3'd6, 32'hFFFFFFFF, "R10 unmapped read");
    ack("R5 empty acknowledge");

    // register widths
    wr(3'd0, 8'h3A);
    rd(3'd0, 32'h0000000A, "R1 task priority keeps low bits");
    wr(3'd4, 8'hC5);
    rd(3'd4, 32'h000000C5, "R5 spurious write");
    ack("R5 empty acknowledge after write");
    wr(3'd0, 8'h02);

    // drops, ties, acknowledge
    fwd(5);
    fwd(12);
    fwd(9);
    fwd(12);
    ack("R4 tie lowest index vector");
    fwd(20);
    ack("R7 top priority vector");
    eoi();
    chk("R9 no raise when raised not above service", {31'd0, irq}, 32'd0);
    eoi();
    chk("R9 raise after service empties", {31'd0, irq}, 32'd1);
    m_active[12] = 1'b0;
    #1;
    ack("R6 inactive winner spurious");
    eoi();
    fwd(30);
    wr(3'd0, 8'h09);
    ack("R6 winner under task priority spurious");
    wr(3'd0, 8'h02);
    fwd(20);
    ack("R7 vector after stale cases");
    eoi();

    // random phase
    for (int n = 0; n < 600; n++) begin
      int op;
      op = int'($urandom % 10);
      if (op < 5) fwd(int'($urandom % N));
      else if (op < 7) ack("R4/R7 random acknowledge");
      else if (op == 7) eoi();
      else if (op == 8) begin
        wr(3'd0, 8'($urandom % 6));
        rd(3'd0, 32'(m_tpr), "R1 random task priority");
      end else begin
        int k;
        k = int'($urandom % N);
        if (m_level[k]) m_active[k] = 1'b0;
        if ($urandom % 4 == 0) wr(3'd4, 8'($urandom));
        else @(negedge clk);
        chk("R11 irq holds", {31'd0, irq}, {31'd0, m_irq});
      end
    end
    finish_run();
  end
endmodule